// File: doc/BRIEF.md
# GPIO Interrupt Controller

A register-mapped general-purpose I/O controller for 8 or 12 pins, reached over a simple 32-bit word bus. The bus has a select, a write strobe, a byte address, write data and combinational read data. Each pin has a direction bit and an output latch, which drive the pad enable and pad value. Each pin also has an input sampled through a two-flop synchronizer, and that synchronized value can be read back.

Every pin can raise an interrupt. Its trigger is chosen from a 3-bit mode field: rising edge, falling edge, both edges, level high or level low. A pending flag per pin is set only while the pin's enable bit is 1. Software clears it by writing ones to a clear register. Per-pin masks are set and cleared through two separate write-one registers. A display register shows the pending flags that are not masked, and one interrupt line is the OR of that view.

A software reset sequence is built as a small state machine with three states:
- `RS_IDLE`: waiting. A write of bit 0 = 1 to the reset word moves it to `RS_ARMED`.
- `RS_ARMED`: a write of bit 0 = 0 to the reset word moves it to `RS_FIRE`. A write of 1 keeps it in `RS_ARMED`.
- `RS_FIRE`: lasts one cycle, during which all configuration and pending state is cleared. It then returns unconditionally to `RS_IDLE`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After hardware reset, every readable word reads 0, `irq` is 0 and `pad_oe` is 0. Masks reset to 0, which means unmasked.
- R2: Direction (0x20) and output (0x18) are plain read/write words. `pad_oe[i]` follows direction bit i, and `pad_out[i]` follows output bit i. Bits at or above the pin count read as 0.
- R3: The input word (0x1C) returns `pad_in` after two synchronizing flops.
- R4: Mode encoding is 0 = falling edge, 1 = rising edge, 2 = level low, 3 = level high, 4 = both edges; 5 to 7 never trigger. Pin i below 8 uses bits 4i..4i+2 of mode-low (0x24). Pin i of 8 or more uses bits 4(i-8)..4(i-8)+2 of mode-high (0x28). Bit 3 of each nibble reads 0.
- R5: A pin's pending bit in the status word (0x04) is set only when its configured event occurs while its enable bit (0x00) is 1. It stays set until cleared.
- R6: A pin in a level mode whose level still holds is pending again in the same cycle its clear is written.
- R7: Writing ones to the clear word (0x0C) clears those pending bits, and zero bits have no effect. Writes to the status, display and input words are ignored.
- R8: Writing ones to mask-set (0x10) masks those pins, and writing ones to mask-clear (0x14) unmasks them. Both words read back the mask.
- R9: The display word (0x08) reads status AND NOT mask, and `irq` is 1 exactly when the display word is non-zero.
- R10: The reset word is at 0x3C. Writing 1 to bit 0 arms it, and bit 0 then reads 1. The next write of 0 to bit 0 clears enable, mask, output, direction, both mode words and status by the following clock. A write of 0 while not armed changes nothing.
- R11: Reserved words (0x2C to 0x38) read 0. Registers change only on cycles with both `bus_sel` and `bus_wr` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pad_in | input | NPINS | Raw pin inputs |
| pad_out | output | NPINS | Output latch values |
| pad_oe | output | NPINS | Output enables (direction bits) |
| irq | output | 1 | Combined interrupt |

## Verification
Wrong state can hide in four places: a lost or stuck pending bit, a mode field decoded from the wrong nibble, a stale mask, or a reset sequencer that fires early or never fires. Each of these shows at the ports as a wrong `irq` level or a wrong display/status word. The effect appears from the third clock after a pad change, once the two synchronizer stages and the pending flop have advanced. A sequencer fault shows within two clocks of the disarming write, as configuration that is not cleared or that is cleared when it should not be. The bench reads the status, display and `irq` views after each stimulus, so a corrupted bit is caught before the next stimulus can mask it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W         = 32;
    localparam int ADDR_W        = 6;
    localparam int FIELD_STRIDE  = 4;
    localparam int FIELD_BITS    = 3;
    localparam int PINS_PER_MODE = BUS_W / FIELD_STRIDE;

    typedef enum logic [3:0] {
        W_ENABLE  = 4'd0,
        W_STATUS  = 4'd1,
        W_DISPLAY = 4'd2,
        W_CLEAR   = 4'd3,
        W_MSET    = 4'd4,
        W_MCLR    = 4'd5,
        W_OUT     = 4'd6,
        W_IN      = 4'd7,
        W_DIR     = 4'd8,
        W_MODE_LO = 4'd9,
        W_MODE_HI = 4'd10,
        W_SWRST   = 4'd15
    } reg_word_e;

    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ARMED = 2'd1,
        RS_FIRE  = 2'd2
    } rst_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = prev_q;

endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_clr,
    input  logic       en,
    input  logic [2:0] mode,
    input  logic       cur,
    input  logic       prev,
    input  logic       clr_hit,
    output logic       status
);

    logic hit;
    logic status_q;

    always_comb begin
        hit = 1'b0;
        unique case (trig_e'(mode))
            TRIG_FALL: hit = prev & ~cur;
            TRIG_RISE: hit = cur & ~prev;
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            TRIG_BOTH: hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
    end

    // a new event wins over a clear written in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (sw_clr)
            status_q <= 1'b0;
        else
            status_q <= (status_q & ~clr_hit) | (hit & en);
    end

    assign status = status_q;

    a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !status_q) |=> !status_q);

    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !en) |=> !status_q);

endmodule

// File: rtl/gpio_reset_seq.sv
module gpio_reset_seq
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic arm_bit,
    output logic sw_clr,
    output logic armed
);

    rst_state_e state_q;
    rst_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (hit && arm_bit)  state_d = RS_ARMED;
            RS_ARMED: if (hit && !arm_bit) state_d = RS_FIRE;
            RS_FIRE:  state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        sw_clr = (state_q == RS_FIRE);
        armed  = (state_q == RS_ARMED);
    end

    a_r10_fire_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FIRE) |=> (state_q == RS_IDLE));

    a_r10_fire_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FIRE) |-> ($past(state_q) == RS_ARMED));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    initial assert (NPINS == 8 || NPINS == 12);

    reg_word_e  word;
    logic       wr;
    logic       sw_clr;
    logic       armed;
    logic       unused_bits;

    logic [NPINS-1:0] en_q, mask_q, out_q, dir_q;
    logic [NPINS-1:0] cur, prev, status, disp;
    logic [2:0]       mode_q  [NPINS];
    logic [31:0]      lo_part [NPINS];
    logic [31:0]      hi_part [NPINS];
    logic [31:0]      mode_lo_rd, mode_hi_rd;

    assign word        = reg_word_e'(bus_addr[5:2]);
    assign wr          = bus_sel & bus_wr;
    assign unused_bits = ^bus_addr[1:0];

    gpio_in_sync #(.N(NPINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .cur    (cur),
        .prev   (prev)
    );

    gpio_reset_seq rseq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (wr && word == W_SWRST),
        .arm_bit (bus_wdata[0]),
        .sw_clr  (sw_clr),
        .armed   (armed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            out_q  <= '0;
            dir_q  <= '0;
        end else if (sw_clr) begin
            en_q   <= '0;
            mask_q <= '0;
            out_q  <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            unique case (word)
                W_ENABLE: en_q   <= bus_wdata[NPINS-1:0];
                W_MSET:   mask_q <= mask_q | bus_wdata[NPINS-1:0];
                W_MCLR:   mask_q <= mask_q & ~bus_wdata[NPINS-1:0];
                W_OUT:    out_q  <= bus_wdata[NPINS-1:0];
                W_DIR:    dir_q  <= bus_wdata[NPINS-1:0];
                default:  ;
            endcase
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (i < PINS_PER_MODE) begin : g_lo
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mode_q[i] <= '0;
                else if (sw_clr)
                    mode_q[i] <= '0;
                else if (wr && word == W_MODE_LO)
                    mode_q[i] <= bus_wdata[FIELD_STRIDE*i +: FIELD_BITS];
            end
            assign lo_part[i] = 32'(mode_q[i]) << (FIELD_STRIDE*i);
            assign hi_part[i] = '0;
        end else begin : g_hi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mode_q[i] <= '0;
                else if (sw_clr)
                    mode_q[i] <= '0;
                else if (wr && word == W_MODE_HI)
                    mode_q[i] <= bus_wdata[FIELD_STRIDE*(i-PINS_PER_MODE) +: FIELD_BITS];
            end
            assign lo_part[i] = '0;
            assign hi_part[i] = 32'(mode_q[i]) << (FIELD_STRIDE*(i-PINS_PER_MODE));
        end

        gpio_trig_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_clr  (sw_clr),
            .en      (en_q[i]),
            .mode    (mode_q[i]),
            .cur     (cur[i]),
            .prev    (prev[i]),
            .clr_hit (wr && word == W_CLEAR && bus_wdata[i]),
            .status  (status[i])
        );
    end

    always_comb begin
        mode_lo_rd = '0;
        mode_hi_rd = '0;
        for (int k = 0; k < NPINS; k++) begin
            mode_lo_rd = mode_lo_rd | lo_part[k];
            mode_hi_rd = mode_hi_rd | hi_part[k];
        end
    end

    assign disp    = status & ~mask_q;
    assign irq     = |disp;
    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    always_comb begin
        case (word)
            W_ENABLE:       bus_rdata = 32'(en_q);
            W_STATUS:       bus_rdata = 32'(status);
            W_DISPLAY:      bus_rdata = 32'(disp);
            W_MSET, W_MCLR: bus_rdata = 32'(mask_q);
            W_OUT:          bus_rdata = 32'(out_q);
            W_IN:           bus_rdata = 32'(cur);
            W_DIR:          bus_rdata = 32'(dir_q);
            W_MODE_LO:      bus_rdata = mode_lo_rd;
            W_MODE_HI:      bus_rdata = mode_hi_rd;
            W_SWRST:        bus_rdata = {31'd0, armed};
            default:        bus_rdata = '0;
        endcase
    end

    a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == W_MSET && !sw_clr) |=>
        ((mask_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    a_r10_config_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (dir_q == '0 && en_q == '0 && mask_q == '0 && status == '0));

    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == W_DIR && !sw_clr) |=> (pad_oe == $past(bus_wdata[NPINS-1:0])));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // scoreboard: kind 0 = read data, 1 = irq, 2 = pad_oe, 3 = pad_out
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_req = 1'b0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always @(negedge clk) begin
        if (mon_req) begin
            if (kind_q.size() == 0) begin
                n_bad++;
                $display("FAIL monitor: got empty queue expected one item");
            end else begin
                int          k;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                case (k)
                    0:       a = bus_rdata;
                    1:       a = {31'd0, irq};
                    2:       a = 32'(pad_oe);
                    default: a = 32'(pad_out);
                endcase
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, a, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk_reg(input logic [5:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
        mon_req = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; mon_req = 1'b0;
    endtask

    task automatic chk_port(input int k, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3); #1;
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk_reg(6'h00, 32'h0, "R1 enable");
        chk_reg(6'h10, 32'h0, "R1 mask");
        chk_reg(6'h20, 32'h0, "R1 dir");
        chk_reg(6'h24, 32'h0, "R1 mode lo");
        chk_reg(6'h04, 32'h0, "R1 status");
        chk_port(1, 32'h0, "R1 irq");
        chk_port(2, 32'h0, "R1 pad_oe");

        // R2 direction and output
        wr_reg(6'h18, 32'h0000_0A5A);
        wr_reg(6'h20, 32'h0000_0FF0);
        chk_port(3, 32'h0A5A, "R2 pad_out");
        chk_port(2, 32'h0FF0, "R2 pad_oe");
        chk_reg(6'h20, 32'h0FF0, "R2 dir read");
        wr_reg(6'h18, 32'hFFFF_FFFF);
        chk_reg(6'h18, 32'h0FFF, "R2 out upper bits zero");

        // R11 reserved word and a read that must not write
        chk_reg(6'h30, 32'h0, "R11 reserved");
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h5;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
        chk_reg(6'h20, 32'h0FF0, "R11 write without select");

        // R3 input readback
        pad_in = 12'h3C5;
        idle(3);
        chk_reg(6'h1C, 32'h03C5, "R3 input");
        pad_in = 12'h000;
        idle(3);

        // R4 modes: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low, 5..7 reserved
        wr_reg(6'h24, 32'h5552_3401);
        chk_reg(6'h24, 32'h5552_3401, "R4 mode lo read");
        wr_reg(6'h00, 32'h0000_00EF);
        idle(3);
        chk_reg(6'h04, 32'h0, "R5 nothing pending, pin4 disabled");

        pad_in = 12'h02F;
        idle(4);
        chk_reg(6'h04, 32'h000D, "R5 rise/both/high set, R4 reserved silent");
        chk_reg(6'h08, 32'h000D, "R9 display");
        chk_port(1, 32'h1, "R9 irq high");

        wr_reg(6'h0C, 32'h0000_000D);
        chk_reg(6'h04, 32'h0008, "R6 level pin pending again");
        pad_in = 12'h027;
        idle(4);
        wr_reg(6'h0C, 32'h0000_0008);
        chk_reg(6'h04, 32'h0, "R7 clear");
        chk_port(1, 32'h0, "R9 irq low");

        pad_in = 12'h020;
        idle(4);
        chk_reg(6'h04, 32'h0006, "R5 fall/both set");

        // R8 masking
        wr_reg(6'h10, 32'h0000_0006);
        chk_reg(6'h08, 32'h0, "R9 display masked");
        chk_port(1, 32'h0, "R8 irq masked");
        chk_reg(6'h04, 32'h0006, "R8 status kept");
        chk_reg(6'h14, 32'h0006, "R8 mask read");
        wr_reg(6'h14, 32'h0000_0002);
        chk_reg(6'h08, 32'h0002, "R9 display partial");
        chk_port(1, 32'h1, "R8 irq unmasked");
        chk_reg(6'h10, 32'h0004, "R8 mask after clear");
        wr_reg(6'h0C, 32'h0000_0006);
        chk_reg(6'h04, 32'h0, "R7 clear two");

        // R5 level low on enable
        wr_reg(6'h00, 32'h0000_01FF);
        idle(2);
        chk_reg(6'h04, 32'h0010, "R5 level low after enable");

        // R4 mode high word
        wr_reg(6'h28, 32'hFFFF_FFFF);
        chk_reg(6'h28, 32'h0000_7777, "R4 mode hi field bits");
        wr_reg(6'h28, 32'h0000_0010);
        wr_reg(6'h00, 32'h0000_03FF);
        pad_in = 12'h220;
        idle(4);
        chk_reg(6'h04, 32'h0210, "R4 pin9 rise via mode hi");

        // R7 status write ignored
        wr_reg(6'h04, 32'h0000_0FFF);
        chk_reg(6'h04, 32'h0210, "R7 status write ignored");

        // R10 reset sequence
        wr_reg(6'h3C, 32'h0);
        chk_reg(6'h20, 32'h0FF0, "R10 zero without arm ignored");
        wr_reg(6'h3C, 32'h1);
        chk_reg(6'h3C, 32'h1, "R10 armed");
        chk_reg(6'h20, 32'h0FF0, "R10 arm alone keeps dir");
        wr_reg(6'h3C, 32'h0);
        idle(2);
        chk_reg(6'h20, 32'h0, "R10 dir cleared");
        chk_reg(6'h00, 32'h0, "R10 enable cleared");
        chk_reg(6'h24, 32'h0, "R10 mode cleared");
        chk_reg(6'h04, 32'h0, "R10 status cleared");
        chk_reg(6'h10, 32'h0, "R10 mask cleared");
        chk_reg(6'h3C, 32'h0, "R10 disarmed");
        chk_port(1, 32'h0, "R10 irq low");
        chk_port(2, 32'h0, "R10 pad_oe low");

        idle(2);
        finish_run();
    end

endmodule